// File: doc/BRIEF.md
# Programmable Watchdog Timer

A 32-bit watchdog that counts down from a software-set reload value. It sits on a simple register bus: address, write strobe, write data and combinational read data, all clocked by the peripheral clock. To restart the count, software must write a fixed 16-bit key. If software stops doing so, the count reaches zero. The block then sets a sticky expiry flag and can drive three outputs: a reset request, an interrupt request and an external signal. The three outputs are enabled separately and share one programmable pulse width.

The count advances on a tick. Software picks the tick source. It is either every peripheral clock cycle or each rising edge of a slower external clock. The external clock is brought into the peripheral clock domain through a flop synchronizer, and its rising edge is turned into a one-cycle tick. The external clock period must be more than twice the peripheral clock period.

Top module: `wdog_timer`

## Requirements
- R1: After reset the counter and the reload register read 0x03EF1480, control reads 0, status reads 0, the pulse length reads 0xFF and all three outputs are low.
- R2: Reads return the register selected by the byte address: 0x00 live counter, 0x04 reload, 0x0C control (bits 4:0), 0x10 status (bit 0), 0x18 pulse length (bits 7:0). The restart address 0x08 and the clear address 0x14 read as 0.
- R3: A write of exactly 0x00005AB9 to address 0x08 copies the reload value into the counter. Any other value written there leaves the counter unchanged.
- R4: While control bit 0 is 1, the counter drops by one on every tick. While it is 0, the counter does not change.
- R5: Once the counter has counted down to zero, it stays at zero until a valid restart.
- R6: Status bit 0 becomes 1 in the same cycle that the counter first reads zero after a decrement. It stays 1 until a write with bit 0 set to address 0x14. A write of 0 there leaves it set.
- R7: Control bit 1 enables the reset output, bit 2 the interrupt output and bit 3 the external output. Each enabled output rises one cycle after the counter first reads zero and stays high for exactly the programmed number of peripheral clock cycles. Outputs that are not enabled stay low.
- R8: A pulse length of 0 produces no pulse on any output.
- R9: With control bit 4 set to 1, the tick is the synchronized rising edge of the external clock, so the counter drops once per external clock period. With bit 4 set to 0, the tick is every peripheral clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk_i | input | 1 | Slow external tick clock, asynchronous to clk |
| bus_addr_i | input | 5 | Byte address of the register |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| rst_pulse_o | output | 1 | Reset request pulse |
| irq_pulse_o | output | 1 | Interrupt request pulse |
| ext_pulse_o | output | 1 | External signal pulse |

## Verification
The countdown is driven with several reload values:
- a long reload that is stopped part way, which shows the step size;
- reloads of one and four that are waited out exactly, which pins down the cycle of expiry;
- an over-wait, which shows the counter holds at zero;
- a disabled run, which shows the enable gate.

The expiry outputs are tried with all three enabled, with only the interrupt enabled, and with a zero length. Together these separate the enable decoding from the width logic.

A near-miss key next to the correct one separates exact key matching from a partial match. Stopping and running the external clock separates the external tick path from the peripheral clock tick.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int unsigned OFS_COUNT   = 5'h00;
   localparam int unsigned OFS_RELOAD  = 5'h04;
   localparam int unsigned OFS_RESTART = 5'h08;
   localparam int unsigned OFS_CTRL    = 5'h0C;
   localparam int unsigned OFS_STATUS  = 5'h10;
   localparam int unsigned OFS_CLEAR   = 5'h14;
   localparam int unsigned OFS_LEN     = 5'h18;

   localparam int unsigned CTL_RUN     = 0;
   localparam int unsigned CTL_RST_EN  = 1;
   localparam int unsigned CTL_IRQ_EN  = 2;
   localparam int unsigned CTL_EXT_EN  = 3;
   localparam int unsigned CTL_EXT_SEL = 4;
   localparam int unsigned CTL_W       = 5;
   localparam int unsigned NUM_OUT     = 3;
endpackage

// File: rtl/wdog_tick_src.sv
module wdog_tick_src #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_clk_i,
   input  logic use_ext_i,
   output logic tick_o
);
   localparam int unsigned LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("wdog_tick_src: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk_i};
         prev_q <= sync_q[LAST];
      end
   end

   assign tick_o = use_ext_i ? (sync_q[LAST] & ~prev_q) : 1'b1;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int unsigned          CNT_W   = 32,
   parameter logic [CNT_W-1:0]     CNT_RST = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic             restart_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             hit_o,
   output logic             evt_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             evt_q;
   logic             step;

   assign step  = run_i & tick_i & (cnt_q != '0) & ~restart_i;
   assign hit_o = step & (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_RST;
         evt_q <= 1'b0;
      end else begin
         evt_q <= hit_o;
         if (restart_i)
            cnt_q <= reload_i;
         else if (step)
            cnt_q <= cnt_q - ONE;
      end
   end

   assign cnt_o = cnt_q;
   assign evt_o = evt_q;
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
   parameter int unsigned LEN_W   = 8,
   parameter int unsigned NUM_OUT = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fire_i,
   input  logic [LEN_W-1:0]   len_i,
   input  logic [NUM_OUT-1:0] en_i,
   output logic [NUM_OUT-1:0] pulse_o
);
   logic [LEN_W-1:0] left_q;
   logic             active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         left_q <= '0;
      else if (fire_i)
         left_q <= len_i;
      else if (active)
         left_q <= left_q - LEN_W'(1);
   end

   assign active = (left_q != '0);

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
      assign pulse_o[i] = active & en_i[i];
   end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
   import wdog_pkg::*;
#(
   parameter int unsigned          DATA_W      = 32,
   parameter int unsigned          ADDR_W      = 5,
   parameter int unsigned          LEN_W       = 8,
   parameter int unsigned          KEY_W       = 16,
   parameter logic [KEY_W-1:0]     RESTART_KEY = 16'h5AB9,
   parameter logic [DATA_W-1:0]    RELOAD_RST  = 32'h03EF1480,
   parameter int unsigned          SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_clk_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_we_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              rst_pulse_o,
   output logic              irq_pulse_o,
   output logic              ext_pulse_o
);
   localparam logic [LEN_W-1:0]  LEN_RST = '1;
   localparam logic [DATA_W-1:0] KEY_WORD = DATA_W'(RESTART_KEY);

   if (DATA_W < KEY_W || DATA_W < LEN_W || DATA_W < CTL_W) begin : g_bad_w
      $error("wdog_timer: DATA_W too narrow for key, length or control");
   end
   if (ADDR_W < 5) begin : g_bad_a
      $error("wdog_timer: ADDR_W must reach offset 0x18");
   end

   logic [DATA_W-1:0]  reload_q;
   logic [CTL_W-1:0]   ctrl_q;
   logic               status_q;
   logic [LEN_W-1:0]   len_q;
   logic [DATA_W-1:0]  cnt_q;
   logic               tick, hit, evt, restart;
   logic [NUM_OUT-1:0] pulses;

   function automatic logic sel(input logic [ADDR_W-1:0] a, input int unsigned ofs);
      return a == ADDR_W'(ofs);
   endfunction

   assign restart = bus_we_i & sel(bus_addr_i, OFS_RESTART) & (bus_wdata_i == KEY_WORD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= RELOAD_RST;
         ctrl_q   <= '0;
         len_q    <= LEN_RST;
         status_q <= 1'b0;
      end else begin
         if (bus_we_i && sel(bus_addr_i, OFS_RELOAD)) reload_q <= bus_wdata_i;
         if (bus_we_i && sel(bus_addr_i, OFS_CTRL))   ctrl_q   <= bus_wdata_i[CTL_W-1:0];
         if (bus_we_i && sel(bus_addr_i, OFS_LEN))    len_q    <= bus_wdata_i[LEN_W-1:0];
         if (hit)
            status_q <= 1'b1;
         else if (bus_we_i && sel(bus_addr_i, OFS_CLEAR) && bus_wdata_i[0])
            status_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata_o = '0;
      if (sel(bus_addr_i, OFS_COUNT))       bus_rdata_o = cnt_q;
      else if (sel(bus_addr_i, OFS_RELOAD)) bus_rdata_o = reload_q;
      else if (sel(bus_addr_i, OFS_CTRL))   bus_rdata_o = DATA_W'(ctrl_q);
      else if (sel(bus_addr_i, OFS_STATUS)) bus_rdata_o = DATA_W'(status_q);
      else if (sel(bus_addr_i, OFS_LEN))    bus_rdata_o = DATA_W'(len_q);
   end

   wdog_tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
      .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk_i),
      .use_ext_i(ctrl_q[CTL_EXT_SEL]), .tick_o(tick)
   );

   wdog_counter #(.CNT_W(DATA_W), .CNT_RST(RELOAD_RST)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run_i(ctrl_q[CTL_RUN]), .tick_i(tick),
      .restart_i(restart), .reload_i(reload_q), .cnt_o(cnt_q),
      .hit_o(hit), .evt_o(evt)
   );

   wdog_pulse #(.LEN_W(LEN_W), .NUM_OUT(NUM_OUT)) u_pulse (
      .clk(clk), .rst_n(rst_n), .fire_i(evt), .len_i(len_q),
      .en_i({ctrl_q[CTL_EXT_EN], ctrl_q[CTL_IRQ_EN], ctrl_q[CTL_RST_EN]}),
      .pulse_o(pulses)
   );

   assign rst_pulse_o = pulses[0];
   assign irq_pulse_o = pulses[1];
   assign ext_pulse_o = pulses[2];
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned CTL_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic              bus_we_i,
   input logic [DATA_W-1:0] bus_wdata_i,
   input logic [DATA_W-1:0] cnt_q,
   input logic [CTL_W-1:0]  ctrl_q,
   input logic              status_q,
   input logic              tick,
   input logic              rst_pulse_o,
   input logic              irq_pulse_o,
   input logic              ext_pulse_o
);
   logic rst_wr, clr_wr;
   assign rst_wr = bus_we_i && bus_addr_i == ADDR_W'(8);
   assign clr_wr = bus_we_i && bus_addr_i == ADDR_W'(20) && bus_wdata_i[0];

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_wr |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - 1)); // R3
   AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[0] && !rst_wr) |=> $stable(cnt_q)); // R4
   AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !rst_wr) |=> cnt_q == '0); // R5
   AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[0] && tick && cnt_q == 1 && !rst_wr) |=> status_q); // R6
   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q && !clr_wr) |=> status_q); // R6
   AST_PULSE_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rst_pulse_o) || $rose(irq_pulse_o) || $rose(ext_pulse_o)) |-> status_q); // R7
endmodule

bind wdog_timer wdog_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTL_W(wdog_pkg::CTL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i),
   .bus_wdata_i(bus_wdata_i), .cnt_q(cnt_q), .ctrl_q(ctrl_q), .status_q(status_q),
   .tick(tick), .rst_pulse_o(rst_pulse_o), .irq_pulse_o(irq_pulse_o),
   .ext_pulse_o(ext_pulse_o)
);

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_clk = 1'b0;
   logic        ext_run = 1'b0;
   logic [4:0]  addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        rst_p, irq_p, ext_p;
   int          checks = 0;
   int          fails = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;
   always begin
      #40;
      if (ext_run) ext_clk = ~ext_clk;
   end

   wdog_timer u_wdog_timer (
      .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk), .bus_addr_i(addr),
      .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .rst_pulse_o(rst_p), .irq_pulse_o(irq_p), .ext_pulse_o(ext_p)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic waitc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic arm(input logic [31:0] reload, input logic [31:0] ctrl);
      wr(5'h0C, 0);
      wr(5'h14, 1);
      wr(5'h04, reload);
      wr(5'h08, 32'h5AB9);
      wr(5'h0C, ctrl);
   endtask

   // reload, ctrl, wait cycles, expected count, expected status
   localparam int NV = 5;
   localparam logic [80:0] VEC [NV] = '{
      {32'd10, 8'h01, 8'd3, 32'd7,  1'b0},
      {32'd4,  8'h01, 8'd4, 32'd0,  1'b1},
      {32'd4,  8'h01, 8'd9, 32'd0,  1'b1},
      {32'd1,  8'h01, 8'd1, 32'd0,  1'b1},
      {32'd20, 8'h00, 8'd5, 32'd20, 1'b0}
   };

   initial begin
      logic [31:0] v, c0;
      int nr, ni, ne;
      waitc(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 and R2: reset values through the read map
      rd(5'h00, v); chk("R1 counter", v, 32'h03EF1480);
      rd(5'h04, v); chk("R1 reload", v, 32'h03EF1480);
      rd(5'h0C, v); chk("R1 control", v, 0);
      rd(5'h10, v); chk("R1 status", v, 0);
      rd(5'h18, v); chk("R1 length", v, 32'hFF);
      chk("R1 outputs", {rst_p, irq_p, ext_p}, 0);
      rd(5'h08, v); chk("R2 restart reads zero", v, 0);
      wr(5'h18, 32'h1FF);
      rd(5'h18, v); chk("R2 length field", v, 32'hFF);
      wr(5'h18, 3);

      // R4 and R5: table walk
      for (int k = 0; k < NV; k++) begin
         arm(VEC[k][80:49], {24'd0, VEC[k][48:41]});
         waitc(int'(VEC[k][40:33]));
         rd(5'h00, v); chk($sformatf("R4/R5 vec%0d count", k), v, VEC[k][32:1]);
         rd(5'h10, v); chk($sformatf("R6 vec%0d status", k), v, {31'd0, VEC[k][0]});
      end

      // R3: near-miss key ignored, exact key reloads (counter disabled at 20)
      wr(5'h04, 99);
      wr(5'h08, 32'h5AB8);
      rd(5'h00, v); chk("R3 wrong key ignored", v, 20);
      wr(5'h08, 32'h15AB9);
      rd(5'h00, v); chk("R3 wide key ignored", v, 20);
      wr(5'h08, 32'h5AB9);
      rd(5'h00, v); chk("R3 key reloads", v, 99);

      // R6: sticky status, clear with bit0 only
      arm(2, 1); waitc(4);
      wr(5'h14, 0);
      rd(5'h10, v); chk("R6 clear with 0 ignored", v, 1);
      wr(5'h14, 1);
      rd(5'h10, v); chk("R6 clear with 1", v, 0);

      // R7: all outputs, length 3
      wr(5'h18, 3);
      arm(4, 32'h0F);
      waitc(4);
      rd(5'h00, v); chk("R7 counter at zero", v, 0);
      chk("R7 no pulse yet", {rst_p, irq_p, ext_p}, 0);
      @(negedge clk);
      chk("R7 pulse starts", {rst_p, irq_p, ext_p}, 3'b111);
      nr = 1; ni = 1; ne = 1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         nr += int'(rst_p); ni += int'(irq_p); ne += int'(ext_p);
      end
      chk("R7 reset width", nr, 3);
      chk("R7 irq width", ni, 3);
      chk("R7 ext width", ne, 3);

      // R7: only interrupt enabled
      wr(5'h18, 2);
      arm(2, 32'h05);
      waitc(3);
      chk("R7 irq only", {rst_p, irq_p, ext_p}, 3'b010);

      // R8: zero length
      wr(5'h18, 0);
      arm(2, 32'h0F);
      nr = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         nr += int'(rst_p | irq_p | ext_p);
      end
      rd(5'h10, v); chk("R8 expired", v, 1);
      chk("R8 no pulse", nr, 0);

      // R9: external tick source
      ext_run = 1'b1;
      arm(200, 32'h11);
      waitc(8);
      rd(5'h00, c0);
      waitc(80);
      rd(5'h00, v);
      chk("R9 ext rate", ((c0 - v) >= 9 && (c0 - v) <= 11), 1);
      ext_run = 1'b0;
      waitc(20);
      rd(5'h00, c0);
      waitc(30);
      rd(5'h00, v); chk("R9 stopped ext clock", v, c0);
      wr(5'h0C, 32'h01);
      rd(5'h00, c0);
      waitc(5);
      rd(5'h00, v); chk("R9 peripheral tick", c0 - v, 5);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule